// File: doc/BRIEF.md
# Two-Way Cache Replacement Tracker

This block keeps the replacement bookkeeping for a two-way set-associative unified cache. It stores a 2-bit code and a pair of tags for every line index. For each lookup it compares the incoming tag against the valid ways of the addressed line and reports a hit and the way that hit. On a miss it names the way to fill and writes the new tag into that way. The per-line code does two jobs. It records how far the line has filled, so way 0 fills first and then way 1. Once both ways hold data, it records which way was used most recently, and the other way is the next victim.

A lookup is offered on a valid/ready pair. `req_ready` is low only in a cycle where `inv_all` is asserted. A lookup is accepted when `req_valid` and `req_ready` are both high. In the same cycle, the block presents its result combinationally on `hit`, `hit_way`, `victim_way` and `fill_en`, and updates the line at the next rising clock edge. The result has no back-pressure of its own: the consumer must use the result in the cycle of acceptance. A requester that sees `req_ready` low holds its request and offers it again.

Line code values: 00 means both ways are invalid. 01 means way 0 is valid and way 1 is invalid. 10 means both ways are valid and way 0 was used most recently. 11 means both ways are valid and way 1 was used most recently.

Top module: `cache_way_tracker`

## Requirements
- R1: After an active-low asynchronous reset, every line holds code 00. The first accepted lookup to any line misses, asserts `fill_en`, and reports `victim_way` = 0.
- R2: A miss on a line in code 00 fills way 0 with the lookup tag and moves the line to code 01. A later lookup of that tag hits with `hit_way` = 0.
- R3: A hit on a line in code 01 leaves the code at 01. The next miss on that line therefore still reports `victim_way` = 1.
- R4: A miss on a line in code 01 fills way 1 and moves the line to code 11. After it, both stored tags hit, on their own ways.
- R5: When both ways are valid, a miss reports as victim the way that was not used most recently. The refilled way becomes the most recent: code 10 goes to 11, and code 11 goes to 10.
- R6: When both ways are valid, a hit on way 1 leaves the line in code 11 and a hit on way 0 leaves it in code 10. The next miss then evicts the other way.
- R7: `hit` is high only when the lookup tag equals the tag of a way that is valid in the line's code. `hit_way` names that way. `fill_en` is exactly the accepted miss. A miss does not alter the tag of the way that is not the victim.
- R8: A cycle with `inv_all` high returns every line to code 00 at the next edge. In that cycle `req_ready` is low and no lookup is accepted: `hit` and `fill_en` stay low.
- R9: When `req_valid` is low, `hit` and `fill_en` are low and no line code or tag changes.
- R10: Lines are independent: a lookup changes only the code and tags of its own index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Synchronous invalidate of every line |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_idx | input | IDX_W | Line index (log2 of LINES) |
| req_tag | input | TAG_W | Tag to compare and, on a miss, to store |
| hit | output | 1 | Accepted lookup matched a valid way |
| hit_way | output | 1 | Way that matched (valid with `hit`) |
| victim_way | output | 1 | Way to fill on a miss |
| fill_en | output | 1 | Accepted lookup missed; the tag is written to `victim_way` |

## Verification
The bench builds the block with LINES = 8 and TAG_W = 4, and draws tags from only four values. With these settings, random lookups revisit each line often. Hits, conflict misses and evictions in every code then occur thousands of times, and a reference model can follow every line in full. Invalidate pulses and idle cycles are scattered through the run, so that refill after invalidation and the hold behaviour are both covered. The tag width and the default of 256 lines are not exercised.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    LS_EMPTY = 2'b00,
    LS_W0    = 2'b01,
    LS_MRU0  = 2'b10,
    LS_MRU1  = 2'b11
  } line_st_e;

  localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/cwt_policy.sv
module cwt_policy
  import cwt_pkg::*;
(
  input  line_st_e cur_st,
  input  logic     is_hit,
  input  logic     hit_way,
  output logic     way0_valid,
  output logic     way1_valid,
  output logic     victim,
  output line_st_e nxt_st
);

  always_comb begin
    way0_valid = (cur_st != LS_EMPTY);
    way1_valid = (cur_st == LS_MRU0) || (cur_st == LS_MRU1);
  end

  always_comb begin
    unique case (cur_st)
      LS_EMPTY: victim = 1'b0;
      LS_W0:    victim = 1'b1;
      LS_MRU0:  victim = 1'b1;
      default:  victim = 1'b0;
    endcase
  end

  always_comb begin
    nxt_st = cur_st;
    if (is_hit) begin
      if (cur_st == LS_MRU0 || cur_st == LS_MRU1)
        nxt_st = hit_way ? LS_MRU1 : LS_MRU0;
    end else begin
      unique case (cur_st)
        LS_EMPTY: nxt_st = LS_W0;
        LS_W0:    nxt_st = LS_MRU1;
        LS_MRU0:  nxt_st = LS_MRU1;
        default:  nxt_st = LS_MRU0;
      endcase
    end
  end

endmodule

// File: rtl/cwt_state_table.sv
module cwt_state_table
  import cwt_pkg::*;
#(
  parameter int unsigned LINES = 256,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  line_st_e         wdata,
  output line_st_e         rdata
);

  line_st_e st_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_EMPTY;
    end else if (clear) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_EMPTY;
    end else if (we) begin
      st_q[idx] <= wdata;
    end
  end

  assign rdata = st_q[idx];

  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!we && !clear) && idx == $past(idx)) |-> rdata == $past(rdata));

  a_r8_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> rdata == LS_EMPTY);

endmodule

// File: rtl/cwt_tag_dir.sv
module cwt_tag_dir #(
  parameter int unsigned LINES = 256,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_way,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag [2]
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) tag_q[idx] <= wr_tag;
    end

    assign rd_tag[w] = tag_q[idx];
  end

endmodule

// File: rtl/cache_way_tracker.sv
module cache_way_tracker
  import cwt_pkg::*;
#(
  parameter int unsigned LINES = 256,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way,
  output logic             fill_en
);

  logic             accept;
  line_st_e         cur_st;
  line_st_e         nxt_st;
  logic             v0, v1;
  logic [1:0]       match;
  logic [TAG_W-1:0] tags [2];
  logic             any_match;

  assign req_ready = !inv_all;
  assign accept    = req_valid && req_ready;

  cwt_state_table #(.LINES(LINES)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (inv_all),
    .we    (accept),
    .idx   (req_idx),
    .wdata (nxt_st),
    .rdata (cur_st)
  );

  cwt_tag_dir #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .wr_en  (fill_en),
    .wr_way (victim_way),
    .idx    (req_idx),
    .wr_tag (req_tag),
    .rd_tag (tags)
  );

  assign match[0]  = v0 && (tags[0] == req_tag);
  assign match[1]  = v1 && (tags[1] == req_tag);
  assign any_match = |match;

  cwt_policy u_policy (
    .cur_st     (cur_st),
    .is_hit     (any_match),
    .hit_way    (match[1]),
    .way0_valid (v0),
    .way1_valid (v1),
    .victim     (victim_way),
    .nxt_st     (nxt_st)
  );

  assign hit     = accept && any_match;
  assign hit_way = match[1];
  assign fill_en = accept && !any_match;

  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $onehot0(match));

  a_r2_first_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && cur_st == LS_EMPTY) |=> (u_state.st_q[$past(req_idx)] == LS_W0));

  a_r3_hold_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cur_st == LS_W0) |=> (u_state.st_q[$past(req_idx)] == LS_W0));

  a_r4_second_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && cur_st == LS_W0) |-> victim_way == 1'b1);

  a_r5_evict_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && v1) |-> (victim_way == (cur_st == LS_MRU0)));

  a_r6_mru_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && v1) |=> (u_state.st_q[$past(req_idx)][0] == $past(hit_way)));

  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> (!hit && !fill_en));

endmodule

// File: tb/cache_way_tracker_tb_top.sv
`timescale 1ns/1ps
module cache_way_tracker_tb_top;

  localparam int unsigned LINES = 8;
  localparam int unsigned TAG_W = 4;
  localparam int unsigned IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_all = 1'b0;
  logic req_valid = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, hit, hit_way, victim_way, fill_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0]       m_st  [LINES];
  logic [TAG_W-1:0] m_tag [LINES][2];

  always #2.5 clk = ~clk;

  cache_way_tracker #(.LINES(LINES), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_tag(req_tag),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way), .fill_en(fill_en)
  );

  function automatic logic exp_victim(input logic [1:0] s);
    return (s == 2'b01) || (s == 2'b10);
  endfunction

  function automatic logic [1:0] exp_next(input logic [1:0] s, input logic h, input logic w);
    if (h) return (s == 2'b01) ? 2'b01 : {1'b1, w};
    if (s == 2'b00) return 2'b01;
    if (s == 2'b11) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check before posedge, model updates at posedge.
  task automatic op(input logic v, input logic inv, input int idx, input int tag, input string req);
    logic e_hit, e_way, e_vic;
    logic [1:0] s;
    @(negedge clk);
    req_valid = v; inv_all = inv; req_idx = idx[IDX_W-1:0]; req_tag = tag[TAG_W-1:0];
    #1;
    s = m_st[idx];
    e_hit = 0; e_way = 0;
    if (s != 2'b00 && m_tag[idx][0] == tag[TAG_W-1:0]) begin e_hit = 1; e_way = 0; end
    if (s[1] && m_tag[idx][1] == tag[TAG_W-1:0]) begin e_hit = 1; e_way = 1; end
    e_vic = exp_victim(s);
    check("R8", "req_ready", req_ready, !inv);
    if (inv || !v) begin
      check(inv ? "R8" : "R9", "hit idle", hit, 0);
      check(inv ? "R8" : "R9", "fill_en idle", fill_en, 0);
    end else begin
      check(req, "hit", hit, e_hit);
      check("R7", "fill_en", fill_en, !e_hit);
      if (e_hit) check("R7", "hit_way", hit_way, e_way);
      else check(req, "victim_way", victim_way, e_vic);
    end
    @(posedge clk);
    if (inv) begin
      for (int i = 0; i < LINES; i++) m_st[i] = 2'b00;
    end else if (v) begin
      if (!e_hit) m_tag[idx][e_vic] = tag[TAG_W-1:0];
      m_st[idx] = exp_next(s, e_hit, e_way);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 2'b00; m_tag[i][0] = '0; m_tag[i][1] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    op(1, 0, 5, 0, "R1");   // reset: empty line misses, victim way 0
    op(1, 0, 3, 1, "R2");   // fill way 0
    op(1, 0, 3, 1, "R2");   // hit way 0
    op(1, 0, 3, 1, "R3");   // hit again, code 01 kept
    op(1, 0, 3, 2, "R4");   // fill way 1 -> 11
    op(1, 0, 3, 1, "R4");
    op(1, 0, 3, 2, "R4");
    op(1, 0, 3, 3, "R5");   // code 11 -> evict way 0
    op(1, 0, 3, 2, "R6");   // hit way 1 -> 11
    op(1, 0, 3, 0, "R6");   // evict way 0
    op(1, 0, 3, 0, "R6");   // hit way 0 -> 10
    op(1, 0, 3, 1, "R5");   // evict way 1
    op(1, 0, 4, 7, "R10");  // neighbour line still empty
    op(0, 0, 3, 9, "R9");   // idle miss-tag, ignored
    op(1, 0, 3, 1, "R9");   // still hits
    op(1, 1, 3, 1, "R8");   // invalidate, not accepted
    op(1, 0, 3, 1, "R8");   // empty again: miss to way 0
    op(1, 0, 4, 7, "R1");

    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) op(1, 1, $urandom_range(0, LINES-1), $urandom_range(0, 3), "R8");
      else if (r < 10) op(0, 0, $urandom_range(0, LINES-1), $urandom_range(0, 3), "R9");
      else op(1, 0, $urandom_range(0, LINES-1), $urandom_range(0, 3), "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule